// File: doc/BRIEF.md
# Endpoint Empty/Oversize Interrupt Status

This block holds one interrupt status bit for each of the seven endpoints of a USB device controller. A bit goes high when its endpoint reports an event, and which event counts depends on how the endpoint is configured. For an OUT endpoint or a control-write endpoint 0, the event is a received packet that is larger than the endpoint's size limit. For an IN endpoint, the event is a transmit buffer that has run dry. For a control-read endpoint 0, the event is the loss of buffer validity, or a buffer-clear command that discards pending transmit data.

The packet engine and the buffer manager send single-cycle event pulses, together with per-endpoint direction, transfer-type and mode levels. The CPU reads the 16-bit status word directly. It clears a bit by writing zero to it, and a bit written with one is left as it is. An oversize packet also sends a one-cycle STALL-force pulse to the response logic of the offending endpoint. On endpoint 0, when the serial-error enable is on, that pulse comes with a control-transfer-error pulse. A masked OR of the status bits drives the interrupt request.

Top module: `epint_status`

## Requirements
- R1: The status word is 16 bits wide. Bit n (n = 0..6) belongs to endpoint n. Bits 15..7 always read as zero.
- R2: The asynchronous hardware reset (rst_n low) clears every status bit. So does a software reset (sw_rst high at a clock edge), which also suppresses the STALL-force and error pulses of that cycle.
- R4: On a CPU write, each status bit whose data bit is 0 is cleared. A status bit whose data bit is 1 keeps its value.
- R5: If a set event and a CPU clear reach the same bit in the same cycle, the bit is 1 afterwards.
- R6: With endpoint 0 in control-write mode (ep0_rd_mode = 0), an oversize pulse sets bit 0 and raises stall_force[0] for one cycle. This does not depend on any response setting.
- R7: When R6 applies and serr_en is 1, ctrl_err_set pulses in the same cycle as stall_force[0]. When serr_en is 0, it stays low.
- R8: With endpoint 0 in control-read mode (ep0_rd_mode = 1), bit 0 is set when ep0_buf_valid falls from 1 to 0, or when ep0_buf_clr arrives while ep0_tx_pending is 1. In this mode, a buffer clear with no pending data and an oversize pulse both have no effect.
- R9: For endpoint k = 1..6 configured as OUT (epn_dir_in[k-1] = 0) and not isochronous, an oversize pulse sets bit k and raises stall_force[k] for one cycle.
- R10: For an OUT endpoint 1..6 marked isochronous (epn_iso[k-1] = 1), an oversize pulse neither sets the bit nor forces STALL.
- R11: For endpoint k = 1..6 configured as IN (epn_dir_in[k-1] = 1), an empty pulse sets bit k without forcing STALL. An oversize pulse on an IN endpoint has no effect, and so does an empty pulse on an OUT endpoint.
- R12: irq is 1 exactly while some status bit and its matching irq_en bit are both 1.
- R13: A status bit never returns to 0 except through a CPU write or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Synchronous software reset |
| ep0_rd_mode | input | 1 | Endpoint 0 direction: 1 = control read, 0 = control write |
| ep0_oversize | input | 1 | Pulse: endpoint 0 received an oversize packet |
| ep0_buf_valid | input | 1 | Level: endpoint 0 transmit buffer holds a valid packet |
| ep0_buf_clr | input | 1 | Pulse: endpoint 0 buffer-clear command |
| ep0_tx_pending | input | 1 | Level: endpoint 0 buffer still holds transmit data |
| serr_en | input | 1 | Enables the control-transfer-error pulse |
| epn_dir_in | input | 6 | Per endpoint 1..6: 1 = IN, 0 = OUT |
| epn_iso | input | 6 | Per endpoint 1..6: isochronous transfer type |
| epn_oversize | input | 6 | Pulses: oversize packet on endpoints 1..6 |
| epn_empty | input | 6 | Pulses: IN buffer ran empty on endpoints 1..6 |
| cpu_wr | input | 1 | CPU write strobe for the status word |
| cpu_wdata | input | 7 | CPU write data; a 0 clears the matching bit |
| irq_en | input | 7 | Per-endpoint interrupt enables |
| status_rdata | output | 16 | Status word as read by the CPU |
| stall_force | output | 7 | One-cycle STALL-force pulses per endpoint |
| ctrl_err_set | output | 1 | One-cycle control-transfer-error pulse |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle: the reserved bits stay zero, a bit never drops without a write or reset, a set beats a simultaneous clear, every STALL pulse is matched by its status bit, an error pulse comes only with an endpoint 0 STALL, and isochronous OUT endpoints never stall. Some behaviour can only be shown by the bench's scenarios. This covers the mode-dependent choice of event for endpoint 0 (a falling valid flag, and a clear with or without pending data), IN versus OUT filtering on endpoints 1..6, interrupt masking, and the asynchronous hardware reset.

// File: rtl/epint_pkg.sv
package epint_pkg;
    localparam int EP_CNT = 7;

    typedef struct packed {
        logic [EP_CNT-1:0] status;
        logic [EP_CNT-1:0] stall;
        logic              ctrt;
    } epint_state_t;
endpackage

// File: rtl/epint_ep0_evt.sv
// Endpoint 0 event qualification: chooses oversize or buffer events by mode.
module epint_ep0_evt (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_mode,
    input  logic oversize,
    input  logic buf_valid,
    input  logic buf_clr,
    input  logic tx_pending,
    input  logic serr_en,
    output logic set_o,
    output logic stall_o,
    output logic ctrt_o
);
    logic valid_d, valid_q;
    logic valid_fell;

    always_comb begin
        valid_d    = buf_valid;
        valid_fell = valid_q & ~buf_valid;
        if (rd_mode) begin
            set_o   = valid_fell | (buf_clr & tx_pending);
            stall_o = 1'b0;
        end else begin
            set_o   = oversize;
            stall_o = oversize;
        end
        ctrt_o = stall_o & serr_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= valid_d;
    end

    // R8: in read mode the oversize path never reaches STALL
    p_rd_no_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_mode |-> !stall_o);
endmodule

// File: rtl/epint_epn_evt.sv
// Endpoint 1..N event qualification: direction and transfer type filter.
module epint_epn_evt (
    input  logic dir_in,
    input  logic iso,
    input  logic oversize,
    input  logic empty,
    output logic set_o,
    output logic stall_o
);
    logic out_ovs;

    always_comb begin
        out_ovs = ~dir_in & oversize & ~iso;
        set_o   = dir_in ? empty : out_ovs;
        stall_o = out_ovs;
    end
endmodule

// File: rtl/epint_status.sv
module epint_status
    import epint_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sw_rst,
    input  logic                 ep0_rd_mode,
    input  logic                 ep0_oversize,
    input  logic                 ep0_buf_valid,
    input  logic                 ep0_buf_clr,
    input  logic                 ep0_tx_pending,
    input  logic                 serr_en,
    input  logic [EP_CNT-2:0]    epn_dir_in,
    input  logic [EP_CNT-2:0]    epn_iso,
    input  logic [EP_CNT-2:0]    epn_oversize,
    input  logic [EP_CNT-2:0]    epn_empty,
    input  logic                 cpu_wr,
    input  logic [EP_CNT-1:0]    cpu_wdata,
    input  logic [EP_CNT-1:0]    irq_en,
    output logic [REG_W-1:0]     status_rdata,
    output logic [EP_CNT-1:0]    stall_force,
    output logic                 ctrl_err_set,
    output logic                 irq
);
    localparam int NUM_EPN = EP_CNT - 1;
    localparam int RSVD_W  = REG_W - EP_CNT;

    logic [EP_CNT-1:0] set_vec;
    logic [EP_CNT-1:0] stall_vec;
    logic              ctrt_evt;
    epint_state_t      st_d, st_q;

    epint_ep0_evt u_ep0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_mode    (ep0_rd_mode),
        .oversize   (ep0_oversize),
        .buf_valid  (ep0_buf_valid),
        .buf_clr    (ep0_buf_clr),
        .tx_pending (ep0_tx_pending),
        .serr_en    (serr_en),
        .set_o      (set_vec[0]),
        .stall_o    (stall_vec[0]),
        .ctrt_o     (ctrt_evt)
    );

    for (genvar k = 1; k <= NUM_EPN; k++) begin : g_epn
        epint_epn_evt u_epn (
            .dir_in   (epn_dir_in[k-1]),
            .iso      (epn_iso[k-1]),
            .oversize (epn_oversize[k-1]),
            .empty    (epn_empty[k-1]),
            .set_o    (set_vec[k]),
            .stall_o  (stall_vec[k])
        );

        // R10: isochronous OUT endpoints never force STALL
        p_iso_no_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (!epn_dir_in[k-1] && epn_iso[k-1]) |=> !stall_force[k]);
    end

    always_comb begin
        st_d = st_q;
        if (sw_rst) begin
            st_d = '0;
        end else begin
            if (cpu_wr) st_d.status = st_q.status & cpu_wdata;
            st_d.status = st_d.status | set_vec;
            st_d.stall  = stall_vec;
            st_d.ctrt   = ctrt_evt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_rdata = {{RSVD_W{1'b0}}, st_q.status};
    assign stall_force  = st_q.stall;
    assign ctrl_err_set = st_q.ctrt;
    assign irq          = |(st_q.status & irq_en);

    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        status_rdata[REG_W-1:EP_CNT] == '0);

    p_sw_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (status_rdata == '0 && stall_force == '0 && !ctrl_err_set));

    p_wr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !sw_rst && set_vec == '0) |=>
            st_q.status == ($past(st_q.status) & $past(cpu_wdata)));

    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_rst |=> ($past(set_vec) & ~st_q.status) == '0);

    p_ep0_ovs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_rst && !ep0_rd_mode && ep0_oversize) |=> (stall_force[0] && st_q.status[0]));

    p_ctrt_with_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_err_set |-> stall_force[0]);

    p_stall_has_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_force & ~st_q.status) == '0);

    p_no_self_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_wr && !sw_rst) |=> (~st_q.status & $past(st_q.status)) == '0);
endmodule

// File: tb/tb_epint_status.sv
`timescale 1ns/1ps
module tb_epint_status;
    localparam int NE = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_rst = 1'b0;
    logic ep0_rd_mode = 1'b0, ep0_oversize = 1'b0, ep0_buf_valid = 1'b0;
    logic ep0_buf_clr = 1'b0, ep0_tx_pending = 1'b0, serr_en = 1'b0;
    logic [NE-2:0] epn_dir_in = '0, epn_iso = '0, epn_oversize = '0, epn_empty = '0;
    logic cpu_wr = 1'b0;
    logic [NE-1:0] cpu_wdata = '1;
    logic [NE-1:0] irq_en = '1;
    logic [15:0] status_rdata;
    logic [NE-1:0] stall_force;
    logic ctrl_err_set, irq;

    always #2.5 clk = ~clk;

    epint_status dut (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
        .ep0_rd_mode(ep0_rd_mode), .ep0_oversize(ep0_oversize),
        .ep0_buf_valid(ep0_buf_valid), .ep0_buf_clr(ep0_buf_clr),
        .ep0_tx_pending(ep0_tx_pending), .serr_en(serr_en),
        .epn_dir_in(epn_dir_in), .epn_iso(epn_iso),
        .epn_oversize(epn_oversize), .epn_empty(epn_empty),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .irq_en(irq_en),
        .status_rdata(status_rdata), .stall_force(stall_force),
        .ctrl_err_set(ctrl_err_set), .irq(irq)
    );

    typedef struct {
        string         tag;
        logic [NE-1:0] st;
        logic [NE-1:0] stl;
        logic          ct;
        logic          iq;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [NE-1:0] m_status = '0;
    logic m_valid = 1'b0;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // monitor: pops one expected item per clock edge that the driver announced
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check({e.tag, " status"}, status_rdata, {9'b0, e.st});
            check("R1 reserved bits", {7'b0, status_rdata[15:7]}, 16'h0);
            check({e.tag, " stall"}, {9'b0, stall_force}, {9'b0, e.stl});
            check({e.tag, " ctrt"}, {15'b0, ctrl_err_set}, {15'b0, e.ct});
            check({e.tag, " irq"}, {15'b0, irq}, {15'b0, e.iq});
        end
    end

    // driver: model the requirements, push the expectation, run one edge
    task automatic tick(input string tag);
        logic [NE-1:0] set, stl;
        logic ct;
        exp_t e;
        set[0] = ep0_rd_mode ? ((m_valid & ~ep0_buf_valid) | (ep0_buf_clr & ep0_tx_pending))
                             : ep0_oversize;
        stl[0] = ~ep0_rd_mode & ep0_oversize;
        ct     = stl[0] & serr_en;
        for (int k = 1; k < NE; k++) begin
            stl[k] = ~epn_dir_in[k-1] & epn_oversize[k-1] & ~epn_iso[k-1];
            set[k] = epn_dir_in[k-1] ? epn_empty[k-1] : stl[k];
        end
        m_valid = ep0_buf_valid;
        if (sw_rst) begin
            m_status = '0; stl = '0; ct = 1'b0;
        end else begin
            m_status = (cpu_wr ? (m_status & cpu_wdata) : m_status) | set;
        end
        e.tag = tag; e.st = m_status; e.stl = stl; e.ct = ct;
        e.iq = |(m_status & irq_en);
        exp_q.push_back(e);
        @(posedge clk);
        @(negedge clk);
        ep0_oversize = 0; ep0_buf_clr = 0; epn_oversize = '0; epn_empty = '0;
        cpu_wr = 0; sw_rst = 0;
    endtask

    task automatic clear_all();
        cpu_wr = 1; cpu_wdata = '0;
        tick("R4 clear all");
        cpu_wdata = '1;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R2 reset status", status_rdata, 16'h0);
        check("R12 reset irq", {15'b0, irq}, 16'h0);

        ep0_oversize = 1; tick("R6 ep0 write oversize");
        cpu_wr = 1; cpu_wdata = '1; tick("R4 write ones keeps");
        cpu_wr = 1; cpu_wdata = 7'h7E; tick("R4 write zero clears");
        cpu_wdata = '1;
        serr_en = 1; ep0_oversize = 1; tick("R7 error pulse");
        serr_en = 0; clear_all();

        ep0_rd_mode = 1;
        ep0_buf_valid = 1; tick("R8 valid rises no set");
        ep0_buf_valid = 0; tick("R8 valid falls sets");
        clear_all();
        ep0_buf_clr = 1; ep0_tx_pending = 0; tick("R8 clear no data ignored");
        ep0_buf_clr = 1; ep0_tx_pending = 1; tick("R8 clear with data sets");
        ep0_tx_pending = 0; clear_all();
        ep0_oversize = 1; tick("R8 oversize in read mode ignored");
        ep0_rd_mode = 0;

        epn_dir_in = 6'b010000;
        epn_oversize[2] = 1; tick("R9 ep3 out oversize");
        clear_all();
        epn_iso[2] = 1; epn_oversize[2] = 1; tick("R10 ep3 iso exempt");
        epn_iso[2] = 0;
        epn_empty[4] = 1; tick("R11 ep5 in empty");
        epn_oversize[4] = 1; tick("R11 in oversize ignored");
        epn_empty[1] = 1; tick("R11 out empty ignored");
        epn_oversize[0] = 1; tick("R9 ep1 out oversize");

        cpu_wr = 1; cpu_wdata = '0; epn_empty[4] = 1; tick("R5 set beats clear");
        cpu_wdata = '1;

        irq_en = 7'b0000001; tick("R12 masked irq");
        irq_en = 7'b0100000; tick("R12 enabled irq");
        irq_en = '1;
        repeat (3) tick("R13 idle hold");

        epn_oversize[5] = 1; tick("R9 ep6 out oversize");
        sw_rst = 1; ep0_oversize = 1; tick("R2 soft reset");

        epn_empty[4] = 1; tick("R11 re-set before hard reset");
        rst_n = 0; #1;
        check("R2 hard reset status", status_rdata, 16'h0);
        check("R2 hard reset irq", {15'b0, irq}, 16'h0);
        m_status = '0; m_valid = 1'b0;
        @(negedge clk); rst_n = 1; @(negedge clk);
        tick("R13 after hard reset");

        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule